// File: doc/BRIEF.md
# Eight-Channel 8-bit PWM Channel Array

This block holds eight separate pulse-width channels, each with an 8-bit counter, an 8-bit period value and an 8-bit duty value. A clock-select stage outside the block supplies one tick per channel. The channel counter advances only on its own tick, so each channel can run at its own rate. Each output is left-aligned: it is active at the start of every period, and it goes inactive once the counter reaches the duty value. Each channel also has an enable bit and a polarity bit.

Software configures the channels through a small register bus. Reads are combinational and writes take effect on the clock edge. New period and duty values wait in holding registers. A running channel copies them in when its period ends. A disabled channel copies them in on the next clock. When a channel is disabled, its pin shows the matching bit of a general-purpose output word and its counter is held at zero. The block has no center alignment and no channel pairing. The control words for those two features always read as zero.

Top module: `pwm8_array`

## Requirements
- R1: A running channel counts ticks from 0 up to period-1 and then returns to 0 on the next tick, so its waveform repeats every `period` ticks. A period of 0 holds the counter at 0.
- R2: When 0 < duty < period, the output is active while the counter is below duty. A period of 4 therefore gives duty steps of 0%, 25%, 50% and 75%.
- R3: A duty of 0 with a non-zero period keeps the output at the inactive level.
- R4: A duty greater than or equal to the period keeps the output at the active level.
- R5: With the polarity bit at 1 the active level is high. With the polarity bit at 0 the output is inverted, so the active level is low.
- R6: While a channel's enable bit is 0, its pin equals the matching bit of `gpio_val`. After reset all registers are 0, so every pin follows `gpio_val`.
- R7: A disabled channel's counter is held at 0. After it is re-enabled, its waveform starts from count 0.
- R8: A period or duty value written while the channel runs takes effect only after the current period ends.
- R9: A period or duty value written while the channel is disabled takes effect on the next clock.
- R10: A counter holds its value in every cycle without its own tick. A tick to one channel does not move any other channel.
- R11: The register map is: enable word at 0x00 (bit n is channel n), polarity word at 0x01 (bit n is channel n), period of channel n at 0x10+n, duty of channel n at 0x18+n. Each of these reads back the value last written. Addresses 0x02 (alignment control) and 0x03 (pairing control) always read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ch_tick | input | 8 | Per-channel counting tick from the clock-select stage |
| gpio_val | input | 8 | General-purpose value shown on a disabled channel's pin |
| pwm_pin | output | 8 | Channel pins |

## Verification
The bench compares every cycle of every pin against an independent model. It aims at four corner cases. The first is the duty-equals-period and duty-zero extremes: a design with an off-by-one compare would leave a one-tick glitch in the output. The second is a period rewrite while the channel runs: a design that loads the new value at once would cut the current period short. The third is disable during mid-period followed by re-enable: a design that keeps the old count would restart out of phase. The fourth is ticks that go to only some channels: a design with shared counting logic would move channels that got no tick. Readback of the unused control words catches writes that should have been ignored.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  localparam int CW = 8;
  localparam int AW = 5;
  typedef logic [CW-1:0] cval_t;

  localparam logic [AW-1:0] A_ENABLE = 5'h00;
  localparam logic [AW-1:0] A_POLAR  = 5'h01;
  localparam logic [AW-1:0] A_ALIGN  = 5'h02;
  localparam logic [AW-1:0] A_JOIN   = 5'h03;
  localparam logic [1:0]    A_PER_HI = 2'b10;
  localparam logic [1:0]    A_DTY_HI = 2'b11;

  // Final count of a period (period 0 counts as a one-state period).
  function automatic logic at_last(cval_t c, cval_t p);
    return (p == '0) || (c >= p - cval_t'(1));
  endfunction

  // Active phase of a left-aligned waveform.
  function automatic logic is_active(cval_t c, cval_t d, cval_t p);
    if (d >= p) return 1'b1;
    return c < d;
  endfunction
endpackage

// File: rtl/pwm8_regs.sv
module pwm8_regs
  import pwm8_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr,
  input  logic [AW-1:0]           addr,
  input  logic [CW-1:0]           wdata,
  output logic [CW-1:0]           rdata,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          pol_o,
  output logic [NCH-1:0][CW-1:0]  per_o,
  output logic [NCH-1:0][CW-1:0]  dty_o
);
  localparam int IW = 3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_o  <= '0;
      pol_o <= '0;
    end else if (wr) begin
      if (addr == A_ENABLE) en_o  <= wdata[NCH-1:0];
      if (addr == A_POLAR)  pol_o <= wdata[NCH-1:0];
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    logic per_hit, dty_hit;
    assign per_hit = wr && (addr == {A_PER_HI, IW'(c)});
    assign dty_hit = wr && (addr == {A_DTY_HI, IW'(c)});
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        per_o[c] <= '0;
        dty_o[c] <= '0;
      end else begin
        if (per_hit) per_o[c] <= wdata;
        if (dty_hit) dty_o[c] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_ENABLE) rdata[NCH-1:0] = en_o;
    if (addr == A_POLAR)  rdata[NCH-1:0] = pol_o;
    for (int c = 0; c < NCH; c++) begin
      if (addr == {A_PER_HI, IW'(c)}) rdata = per_o[c];
      if (addr == {A_DTY_HI, IW'(c)}) rdata = dty_o[c];
    end
  end
endmodule

// File: rtl/pwm8_chan.sv
module pwm8_chan
  import pwm8_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    en,
  input  logic    pol,
  input  cval_t   per_new,
  input  cval_t   dty_new,
  input  logic    gpio,
  output logic    pin,
  output cval_t   cnt_o,
  output cval_t   per_o,
  output cval_t   dty_o,
  output logic    wrap_o
);
  cval_t cnt_q, per_q, dty_q;
  logic  last, act, lvl;

  assign last   = at_last(cnt_q, per_q);
  assign wrap_o = en && tick && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= '0;
      dty_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
      per_q <= per_new;
      dty_q <= dty_new;
    end else if (tick) begin
      if (last) begin
        cnt_q <= '0;
        per_q <= per_new;
        dty_q <= dty_new;
      end else begin
        cnt_q <= cnt_q + cval_t'(1);
      end
    end
  end

  assign act = is_active(cnt_q, dty_q, per_q);
  assign lvl = pol ? act : !act;
  assign pin = en ? lvl : gpio;

  assign cnt_o = cnt_q;
  assign per_o = per_q;
  assign dty_o = dty_q;
endmodule

// File: rtl/pwm8_array.sv
module pwm8_array
  import pwm8_pkg::*;
#(
  parameter int NCH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [4:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NCH-1:0]  ch_tick,
  input  logic [NCH-1:0]  gpio_val,
  output logic [NCH-1:0]  pwm_pin
);
  logic [NCH-1:0]          en_q, pol_q, wrap_v;
  logic [NCH-1:0][CW-1:0]  per_r, dty_r, cnt_v, pact_v, dact_v;

  pwm8_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .en_o(en_q), .pol_o(pol_q), .per_o(per_r), .dty_o(dty_r)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    pwm8_chan u_ch (
      .clk(clk), .rst_n(rst_n), .tick(ch_tick[c]), .en(en_q[c]),
      .pol(pol_q[c]), .per_new(per_r[c]), .dty_new(dty_r[c]),
      .gpio(gpio_val[c]), .pin(pwm_pin[c]),
      .cnt_o(cnt_v[c]), .per_o(pact_v[c]), .dty_o(dact_v[c]),
      .wrap_o(wrap_v[c])
    );
  end
endmodule

// File: rtl/pwm8_checker.sv
module pwm8_checker
  import pwm8_pkg::*;
#(
  parameter int NCH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NCH-1:0]         en,
  input logic [NCH-1:0]         tick,
  input logic [NCH-1:0]         pol,
  input logic [4:0]             addr,
  input logic [7:0]             rdata,
  input logic [NCH-1:0]         pin,
  input logic [NCH-1:0][CW-1:0] cnt,
  input logic [NCH-1:0][CW-1:0] pact,
  input logic [NCH-1:0][CW-1:0] dact,
  input logic [NCH-1:0]         wrap
);
  AST_UNUSED_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_ALIGN || addr == A_JOIN) |-> rdata == 8'h00); // R11

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && pact[c] != '0) |-> cnt[c] < pact[c]); // R1
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      wrap[c] |=> cnt[c] == '0); // R1
    AST_IDLE_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !en[c] |=> cnt[c] == '0); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && !tick[c]) |=> $stable(cnt[c])); // R10
    AST_ZERO_DUTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && dact[c] == '0 && pact[c] != '0) |-> pin[c] == !pol[c]); // R3
    AST_FULL_DUTY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (en[c] && dact[c] >= pact[c]) |-> pin[c] == pol[c]); // R4
  end
endmodule

bind pwm8_array pwm8_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .tick(ch_tick), .pol(pol_q),
  .addr(bus_addr), .rdata(bus_rdata), .pin(pwm_pin),
  .cnt(cnt_v), .pact(pact_v), .dact(dact_v), .wrap(wrap_v)
);

// File: tb/pwm8_array_test.sv
module pwm8_array_test;
  localparam int TCLK = 10;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] ch_tick = '0;
  logic [7:0] gpio_val = '0;
  logic [7:0] pwm_pin;

  pwm8_array uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_tick(ch_tick),
    .gpio_val(gpio_val), .pwm_pin(pwm_pin)
  );

  always #(TCLK/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  string cur_tag = "R6";

  // independent model
  logic [7:0] m_en = '0, m_pol = '0;
  logic [7:0] m_per [N];
  logic [7:0] m_dty [N];
  logic [7:0] m_cnt [N];
  logic [7:0] m_pa  [N];
  logic [7:0] m_da  [N];

  logic [7:0] q_exp [$];
  string      q_tag [$];

  initial begin
    for (int c = 0; c < N; c++) begin
      m_per[c] = 0; m_dty[c] = 0; m_cnt[c] = 0; m_pa[c] = 0; m_da[c] = 0;
    end
  end

  function automatic logic [7:0] predict();
    logic [7:0] r;
    for (int c = 0; c < N; c++) begin
      logic on;
      on = (m_da[c] >= m_pa[c]) || (m_cnt[c] < m_da[c]);
      if (!m_en[c]) r[c] = gpio_val[c];
      else r[c] = m_pol[c] ? on : !on;
    end
    return r;
  endfunction

  task automatic model_edge(input logic w, input logic [4:0] a,
                            input logic [7:0] d, input logic [7:0] tk);
    for (int c = 0; c < N; c++) begin
      if (!m_en[c]) begin
        m_cnt[c] = 0; m_pa[c] = m_per[c]; m_da[c] = m_dty[c];
      end else if (tk[c]) begin
        if (m_pa[c] == 0 || m_cnt[c] + 1 >= m_pa[c]) begin
          m_cnt[c] = 0; m_pa[c] = m_per[c]; m_da[c] = m_dty[c];
        end else m_cnt[c] = m_cnt[c] + 1;
      end
    end
    if (w) begin
      if (a == 5'h00) m_en = d;
      else if (a == 5'h01) m_pol = d;
      else if (a[4:3] == 2'b10) m_per[a[2:0]] = d;
      else if (a[4:3] == 2'b11) m_dty[a[2:0]] = d;
    end
  endtask

  // driver: one clock cycle; optional combinational readback check
  task automatic cyc(input logic w, input logic [4:0] a, input logic [7:0] d,
                     input logic [7:0] tk, input logic rchk, input logic [7:0] rexp);
    @(negedge clk);
    #1;
    bus_wr = w; bus_addr = a; bus_wdata = d; ch_tick = tk;
    #1;
    if (rchk) begin
      n_chk++;
      if (bus_rdata !== rexp) begin
        n_bad++;
        $display("FAIL %s readback addr=%h actual=%h expected=%h", cur_tag, a, bus_rdata, rexp);
      end
    end
    @(posedge clk);
    if (rst_n) begin
      model_edge(w, a, d, tk);
      q_exp.push_back(predict());
      q_tag.push_back(cur_tag);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 8'h00, 1'b0, 8'h00);
  endtask

  task automatic run(input int n, input logic [7:0] tk);
    for (int i = 0; i < n; i++) cyc(1'b0, 5'h00, 8'h00, tk, 1'b0, 8'h00);
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e);
    cyc(1'b0, a, 8'h00, 8'h00, 1'b1, e);
  endtask

  // monitor: pops one expected pin word per cycle
  always @(negedge clk) begin
    if (q_exp.size() > 0) begin
      logic [7:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_chk++;
      if (pwm_pin !== e) begin
        n_bad++;
        $display("FAIL %s pins actual=%b expected=%b", t, pwm_pin, e);
      end
    end
  end

  initial begin
    repeat (400000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    gpio_val = 8'hA5;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;

    // R6 reset state: pins follow gpio, registers zero (R11)
    cur_tag = "R6";
    run(3, 8'hFF);
    cur_tag = "R11";
    rd(5'h00, 8'h00);
    rd(5'h13, 8'h00);

    // configure: R2 quarter steps, R3 zero duty, R4 full duty, R5 inverted ch6
    cur_tag = "R2";
    wr(5'h10, 8'd4); wr(5'h18, 8'd1);
    wr(5'h11, 8'd4); wr(5'h19, 8'd2);
    wr(5'h12, 8'd4); wr(5'h1A, 8'd3);
    wr(5'h13, 8'd4); wr(5'h1B, 8'd0);
    wr(5'h14, 8'd3); wr(5'h1C, 8'd5);
    wr(5'h15, 8'd10); wr(5'h1D, 8'd10);
    wr(5'h16, 8'd5); wr(5'h1E, 8'd2);
    wr(5'h17, 8'd7); wr(5'h1F, 8'd3);
    wr(5'h01, 8'hBF);
    wr(5'h00, 8'hFF);
    cur_tag = "R1";  run(24, 8'hFF);
    cur_tag = "R3";  run(4, 8'hFF);
    cur_tag = "R4";  run(4, 8'hFF);
    cur_tag = "R5";  run(6, 8'hFF);

    // R10 partial ticks
    cur_tag = "R10";
    for (int i = 0; i < 30; i++) run(1, (i % 3 == 0) ? 8'hFF : 8'h0F);
    run(10, 8'h50);

    // R8 rewrite while running
    cur_tag = "R8";
    wr(5'h10, 8'd6); wr(5'h18, 8'd3);
    run(16, 8'hFF);

    // R7 disable in mid-period, then re-enable
    cur_tag = "R6";
    gpio_val = 8'h5A;
    run(1, 8'hFF);
    wr(5'h00, 8'hFD);
    run(4, 8'hFF);
    cur_tag = "R7";
    wr(5'h00, 8'hFF);
    run(10, 8'hFF);

    // R9 write while disabled
    cur_tag = "R9";
    wr(5'h00, 8'hFB);
    wr(5'h12, 8'd2); wr(5'h1A, 8'd1);
    wr(5'h00, 8'hFF);
    run(8, 8'hFF);

    // R11 readback and ignored control words
    cur_tag = "R11";
    wr(5'h02, 8'hFF); wr(5'h03, 8'hFF);
    rd(5'h02, 8'h00);
    rd(5'h03, 8'h00);
    rd(5'h00, 8'hFF);
    rd(5'h01, 8'hBF);
    rd(5'h10, 8'd6);
    rd(5'h1E, 8'd2);
    rd(5'h1A, 8'd1);
    run(6, 8'hFF);

    run(2, 8'h00);
    @(negedge clk); @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule